// File: doc/BRIEF.md
# Per-Process Page Remapping MMU

This block translates CPU virtual addresses that fall inside a 128 KB internal RAM window into physical addresses. The window is split into sixteen pages. The page size is selected at run time as 8 KB, 4 KB or 2 KB. With the two smaller sizes, the sixteen pages do not reach the top of the window, and the remaining tail is left untranslated. Each offset inside a page is carried across unchanged. Only the page-number bits are swapped for the physical page number.

The two privileged process IDs (0 and 1) always see an identity mapping, so supervisor code can reach all of physical memory. Process IDs 2 to 7 each own a private sixteen-entry table of 4-bit physical page numbers. These tables are loaded through a simple indexed write port. Translation is combinational from the registered tables, so a lookup costs no latency. A table write is seen by accesses from the following cycle.

Top module: `mmu_remap`

## Requirements
- R1: The window is 128 KB starting at 0x3FFC_0000 and holds 16 pages. The page-size code selects the page index bits: `pg_size`=00 gives 8 KB pages with index va[16:13]; 01 gives 4 KB pages with index va[15:12]; 10 and 11 both give 2 KB pages with index va[14:11].
- R2: For a covered access, every address bit outside the selected page-index field is copied from `va` to `pa`. That field is replaced by the physical page number.
- R3: For PID 0 or 1, a covered access gives `pa` equal to `va`. Table writes that name PID 0 or 1 have no effect.
- R4: For PIDs 2 to 7, the physical page comes from that PID's own table entry. A write to one PID's table does not change another PID's mapping. Example: with 8 KB pages and entry (PID 2, page 1) = 2, va 0x3FFC_2345 translates to 0x3FFC_4345.
- R5: With 4 KB pages, the top 64 KB of the window (va[16]=1) is uncovered. With 2 KB pages, the top 96 KB (va[16:15]≠0) is uncovered. For an uncovered address, `covered`=0 and `pa`=`va`.
- R6: An address outside the window gives `covered`=0 and `pa`=`va`.
- R7: While `va_valid`=0, `covered`=0 and `pa`=`va`.
- R8: After reset, every table entry holds its own virtual page number, so every PID starts with an identity mapping.
- R9: A table write made in one cycle does not change translation in that cycle. It takes effect from the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| va_valid | input | 1 | Access strobe |
| va | input | 32 | Virtual address |
| pid | input | 3 | Process ID of the current access |
| pg_size | input | 2 | Page-size code (00 8 KB, 01 4 KB, 1x 2 KB) |
| wr_en | input | 1 | Table write strobe |
| wr_pid | input | 3 | PID whose table is written |
| wr_vpage | input | 4 | Virtual page entry to write |
| wr_ppage | input | 4 | Physical page number stored |
| pa | output | 32 | Physical address |
| covered | output | 1 | Access was translated by the MMU |

## Verification
The assertions assume that `va`, `pid` and `pg_size` are stable between clock edges, because they compare combinational outputs at the edge. They also assume that a write names a PID in the range 0 to 7, which holds for any 3-bit value. The bench changes every input only at the falling edge and samples two nanoseconds later. It performs table writes only in dedicated cycles, except in the one test that deliberately overlaps a write with a lookup to show the one-cycle visibility rule.

// File: rtl/mmu_remap_pkg.sv
package mmu_remap_pkg;
   typedef enum logic [1:0] {
      PGSZ_8K   = 2'b00,
      PGSZ_4K   = 2'b01,
      PGSZ_2K   = 2'b10,
      PGSZ_2K_B = 2'b11
   } pgsz_e;

   // number of halvings of the largest page size
   function automatic logic [1:0] pgsz_step(input logic [1:0] code);
      return (code == PGSZ_2K_B) ? 2'd2 : code;
   endfunction
endpackage

// File: rtl/mmu_addr_split.sv
module mmu_addr_split
   import mmu_remap_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned REGION_BITS = 17,
   parameter int unsigned PAGE_W      = 4,
   parameter logic [ADDR_W-1:0] REGION_BASE = 32'h3FFC_0000,
   localparam int unsigned SH_W       = $clog2(REGION_BITS + 1)
) (
   input  logic              va_valid,
   input  logic [ADDR_W-1:0] va,
   input  logic [1:0]        pg_size,
   output logic              covered,
   output logic [PAGE_W-1:0] vpage,
   output logic [SH_W-1:0]   shift
);
   localparam int unsigned SHIFT_MAX = REGION_BITS - PAGE_W;

   logic [REGION_BITS-1:0] rel;
   logic [REGION_BITS-1:0] rel_idx;
   logic [REGION_BITS-1:0] rel_tail;
   logic                   in_region;

   always_comb begin
      rel       = va[REGION_BITS-1:0];
      shift     = SH_W'(SHIFT_MAX) - SH_W'(pgsz_step(pg_size));
      rel_idx   = rel >> shift;
      rel_tail  = rel >> (shift + SH_W'(PAGE_W));
      vpage     = rel_idx[PAGE_W-1:0];
      in_region = (va[ADDR_W-1:REGION_BITS] == REGION_BASE[ADDR_W-1:REGION_BITS]);
      covered   = va_valid && in_region && (rel_tail == '0);
   end
endmodule

// File: rtl/mmu_page_table.sv
module mmu_page_table #(
   parameter int unsigned NPID   = 8,
   parameter int unsigned NPRIV  = 2,
   parameter int unsigned PAGES  = 16,
   localparam int unsigned PID_W  = $clog2(NPID),
   localparam int unsigned PAGE_W = $clog2(PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PID_W-1:0]  wr_pid,
   input  logic [PAGE_W-1:0] wr_vpage,
   input  logic [PAGE_W-1:0] wr_ppage,
   input  logic [PID_W-1:0]  rd_pid,
   input  logic [PAGE_W-1:0] rd_vpage,
   output logic [PAGE_W-1:0] rd_ppage
);
   localparam int unsigned NPROC = NPID - NPRIV;

   logic [PAGE_W-1:0] tbl [NPROC][PAGES];
   logic [PID_W-1:0]  wr_slot;
   logic [PID_W-1:0]  rd_slot;
   logic              wr_mapped;

   assign wr_slot   = wr_pid - PID_W'(NPRIV);
   assign rd_slot   = rd_pid - PID_W'(NPRIV);
   assign wr_mapped = wr_en && (wr_pid >= PID_W'(NPRIV));

   for (genvar p = 0; p < NPROC; p++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int v = 0; v < PAGES; v++) tbl[p][v] <= PAGE_W'(v);
         end else if (wr_mapped && wr_slot == PID_W'(p)) begin
            tbl[p][wr_vpage] <= wr_ppage;
         end
      end
   end

   if (NPRIV > 0) begin : g_priv
      assign rd_ppage = (rd_pid < PID_W'(NPRIV)) ? rd_vpage : tbl[rd_slot][rd_vpage];
   end else begin : g_nopriv
      assign rd_ppage = tbl[rd_slot][rd_vpage];
   end

   // R9: a captured write lands in the addressed entry on the next cycle
   p_wr_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mapped |=> tbl[$past(wr_slot)][$past(wr_vpage)] == $past(wr_ppage));
endmodule

// File: rtl/mmu_addr_merge.sv
module mmu_addr_merge #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PAGE_W = 4,
   parameter int unsigned SH_W   = 5
) (
   input  logic [ADDR_W-1:0] va,
   input  logic              covered,
   input  logic [PAGE_W-1:0] ppage,
   input  logic [SH_W-1:0]   shift,
   output logic [ADDR_W-1:0] pa
);
   logic [ADDR_W-1:0] field;
   logic [ADDR_W-1:0] placed;

   always_comb begin
      field  = {{(ADDR_W-PAGE_W){1'b0}}, {PAGE_W{1'b1}}} << shift;
      placed = {{(ADDR_W-PAGE_W){1'b0}}, ppage} << shift;
      pa     = covered ? ((va & ~field) | placed) : va;
   end
endmodule

// File: rtl/mmu_remap.sv
module mmu_remap
   import mmu_remap_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned REGION_BITS = 17,
   parameter int unsigned PAGES       = 16,
   parameter int unsigned NPID        = 8,
   parameter int unsigned NPRIV       = 2,
   parameter logic [ADDR_W-1:0] REGION_BASE = 32'h3FFC_0000,
   localparam int unsigned PAGE_W = $clog2(PAGES),
   localparam int unsigned PID_W  = $clog2(NPID),
   localparam int unsigned SH_W   = $clog2(REGION_BITS + 1),
   localparam int unsigned MIN_OFS = REGION_BITS - PAGE_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              va_valid,
   input  logic [ADDR_W-1:0] va,
   input  logic [PID_W-1:0]  pid,
   input  logic [1:0]        pg_size,
   input  logic              wr_en,
   input  logic [PID_W-1:0]  wr_pid,
   input  logic [PAGE_W-1:0] wr_vpage,
   input  logic [PAGE_W-1:0] wr_ppage,
   output logic [ADDR_W-1:0] pa,
   output logic              covered
);
   if (PAGES != (1 << PAGE_W)) begin : g_bad_pages
      $error("PAGES must be a power of two");
   end
   if (REGION_BITS < PAGE_W + 3 || REGION_BITS >= ADDR_W) begin : g_bad_region
      $error("REGION_BITS too small for three page sizes");
   end
   if (NPRIV >= NPID) begin : g_bad_priv
      $error("NPRIV must leave at least one mapped PID");
   end
   if (REGION_BASE[REGION_BITS-1:0] != '0) begin : g_bad_base
      $error("REGION_BASE must be aligned to the window size");
   end

   logic [PAGE_W-1:0] vpage;
   logic [PAGE_W-1:0] ppage;
   logic [SH_W-1:0]   shift;

   mmu_addr_split #(
      .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS), .PAGE_W(PAGE_W), .REGION_BASE(REGION_BASE)
   ) i_split (
      .va_valid(va_valid), .va(va), .pg_size(pg_size),
      .covered(covered), .vpage(vpage), .shift(shift)
   );

   mmu_page_table #(.NPID(NPID), .NPRIV(NPRIV), .PAGES(PAGES)) i_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_pid(wr_pid), .wr_vpage(wr_vpage), .wr_ppage(wr_ppage),
      .rd_pid(pid), .rd_vpage(vpage), .rd_ppage(ppage)
   );

   mmu_addr_merge #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SH_W(SH_W)) i_merge (
      .va(va), .covered(covered), .ppage(ppage), .shift(shift), .pa(pa)
   );

   // R2: bits below the smallest page and above the window always survive
   p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      covered |-> (pa[MIN_OFS-1:0] == va[MIN_OFS-1:0]) &&
                  (pa[ADDR_W-1:REGION_BITS] == va[ADDR_W-1:REGION_BITS]));
   // R3: privileged PIDs see identity
   p_priv_identity_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (covered && pid < PID_W'(NPRIV)) |-> pa == va);
   // R5: uncovered accesses pass through
   p_uncov_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !covered |-> pa == va);
   // R6: outside the window nothing is covered
   p_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (va[ADDR_W-1:REGION_BITS] != REGION_BASE[ADDR_W-1:REGION_BITS]) |-> !covered);
   // R7: no strobe, no coverage
   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !va_valid |-> !covered);
endmodule

// File: tb/test_mmu_remap.sv
`timescale 1ns/1ps
module test_mmu_remap;
   typedef struct packed {
      logic [2:0]  pid;
      logic [1:0]  pg;
      logic [31:0] va;
      logic [31:0] pa;
      logic        cov;
   } vec_t;

   localparam int NV = 14;
   // table preload: (2,1)->2, (3,1)->9, (7,15)->0
   localparam vec_t VECS [NV] = '{
      '{3'd2, 2'b00, 32'h3FFC_2345, 32'h3FFC_4345, 1'b1}, // R4 worked example
      '{3'd3, 2'b00, 32'h3FFC_2345, 32'h3FFD_2345, 1'b1}, // R4 other PID
      '{3'd0, 2'b00, 32'h3FFC_2345, 32'h3FFC_2345, 1'b1}, // R3
      '{3'd1, 2'b00, 32'h3FFC_2345, 32'h3FFC_2345, 1'b1}, // R3
      '{3'd4, 2'b00, 32'h3FFC_2345, 32'h3FFC_2345, 1'b1}, // R4 untouched PID
      '{3'd7, 2'b00, 32'h3FFD_FFFF, 32'h3FFC_1FFF, 1'b1}, // R2 top page
      '{3'd2, 2'b01, 32'h3FFC_1345, 32'h3FFC_2345, 1'b1}, // R1 4KB
      '{3'd2, 2'b01, 32'h3FFD_0000, 32'h3FFD_0000, 1'b0}, // R5 4KB tail
      '{3'd2, 2'b10, 32'h3FFC_0ABC, 32'h3FFC_12BC, 1'b1}, // R1 2KB
      '{3'd2, 2'b10, 32'h3FFC_8000, 32'h3FFC_8000, 1'b0}, // R5 2KB tail
      '{3'd3, 2'b10, 32'h3FFC_7FFF, 32'h3FFC_7FFF, 1'b1}, // R5 last covered 2KB
      '{3'd2, 2'b00, 32'h4000_0000, 32'h4000_0000, 1'b0}, // R6
      '{3'd3, 2'b01, 32'h3FFC_1800, 32'h3FFC_9800, 1'b1}, // R2 4KB offset
      '{3'd2, 2'b11, 32'h3FFC_0ABC, 32'h3FFC_12BC, 1'b1}  // R1 code 11
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        va_valid = 1'b0;
   logic [31:0] va = '0;
   logic [2:0]  pid = '0;
   logic [1:0]  pg_size = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_pid = '0;
   logic [3:0]  wr_vpage = '0;
   logic [3:0]  wr_ppage = '0;
   logic [31:0] pa;
   logic        covered;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mmu_remap i_mmu_remap (
      .clk(clk), .rst_n(rst_n), .va_valid(va_valid), .va(va), .pid(pid), .pg_size(pg_size),
      .wr_en(wr_en), .wr_pid(wr_pid), .wr_vpage(wr_vpage), .wr_ppage(wr_ppage),
      .pa(pa), .covered(covered)
   );

   task automatic check(input string req, input logic [31:0] exp_pa, input logic exp_cov);
      n_chk++;
      if (pa !== exp_pa || covered !== exp_cov) begin
         n_bad++;
         $display("FAIL %s: pa=%h cov=%b expected pa=%h cov=%b", req, pa, covered, exp_pa, exp_cov);
      end
   endtask

   task automatic access(input logic [2:0] p, input logic [1:0] g, input logic [31:0] a);
      @(negedge clk);
      va_valid = 1'b1; pid = p; pg_size = g; va = a;
      #2;
   endtask

   task automatic tbl_write(input logic [2:0] p, input logic [3:0] v, input logic [3:0] pp);
      @(negedge clk);
      wr_en = 1'b1; wr_pid = p; wr_vpage = v; wr_ppage = pp;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: identity after reset for mapped PIDs
      access(3'd5, 2'b00, 32'h3FFC_2345); check("R8", 32'h3FFC_2345, 1'b1);
      access(3'd7, 2'b10, 32'h3FFC_3C10); check("R8", 32'h3FFC_3C10, 1'b1);
      // R7: strobe low
      access(3'd2, 2'b00, 32'h3FFC_2345); va_valid = 1'b0; #1;
      check("R7", 32'h3FFC_2345, 1'b0);

      tbl_write(3'd2, 4'd1, 4'd2);
      tbl_write(3'd3, 4'd1, 4'd9);
      tbl_write(3'd7, 4'd15, 4'd0);
      tbl_write(3'd1, 4'd1, 4'd5); // R3: must be ignored
      tbl_write(3'd0, 4'd3, 4'd7); // R3: must be ignored

      for (int i = 0; i < NV; i++) begin
         access(VECS[i].pid, VECS[i].pg, VECS[i].va);
         check($sformatf("vector %0d (R1-R6 set)", i), VECS[i].pa, VECS[i].cov);
      end

      // R3: writes aimed at privileged PIDs left identity
      access(3'd0, 2'b00, 32'h3FFC_6000); check("R3", 32'h3FFC_6000, 1'b1);

      // R9: overlap a write with a lookup of the same entry
      @(negedge clk);
      va_valid = 1'b1; pid = 3'd6; pg_size = 2'b00; va = 32'h3FFC_4010;
      wr_en = 1'b1; wr_pid = 3'd6; wr_vpage = 4'd2; wr_ppage = 4'd3;
      #2; check("R9 before edge", 32'h3FFC_4010, 1'b1);
      @(negedge clk); wr_en = 1'b0;
      #2; check("R9 after edge", 32'h3FFC_6010, 1'b1);
      // R4: PID 5 page 2 unaffected by PID 6 write
      access(3'd5, 2'b00, 32'h3FFC_4010); check("R4", 32'h3FFC_4010, 1'b1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule